// File: doc/BRIEF.md
# Receive Descriptor Ring Run Controller

This block decides when a receive DMA engine walks its ring of descriptors in memory. Software enables or disables the engine with a single run bit and programs a table base address. While the engine runs, the block requests each descriptor from a memory port and examines the descriptor's available flag. When the flag is set, the block hands the frame to a data mover through a start/done handshake and then moves on to the next descriptor. When the flag is clear, the block parks in a suspend state and raises a sticky no-buffer flag.

A disable request that arrives during a frame transfer is held until the data mover reports done. A disable request that arrives during a descriptor fetch is held until the fetch response returns. After a stop, a later enable resumes at the descriptor that follows the last one consumed, unless a new table base has been written since the last run began. From suspend, an enable fetches the same descriptor again. The current descriptor address and a two-bit run state are visible at the outputs.

Top module: `rxdma_run_ctl`

## Requirements
- R1: After reset, run_state_o is 0 (stop), cur_addr_o is 0, nobuf_o is 0, and neither fetch_req_o nor xfer_start_o is asserted.
- R2: An enable write (run_wr_i with run_val_i=1) in stop, after a base write since the last start, moves run_state_o to 1 (running) in the next cycle and requests the descriptor at the new base.
- R3: An enable write in stop with no base write since the last start requests the descriptor held in cur_addr_o, which is the one after the last descriptor consumed.
- R4: A fetch response with fetch_avail_i=1 gives exactly one xfer_start_o pulse, in the cycle after the response, while run_state_o stays 1.
- R5: On xfer_done_i the address advances by DESC_BYTES (default 16), or returns to the table base when that descriptor had fetch_eor_i=1. The next fetch then goes to the new address.
- R6: A fetch response with fetch_avail_i=0 (and no pending stop) moves run_state_o to 2 (suspend), sets nobuf_o, and starts no transfer.
- R7: An enable write in suspend fetches the same descriptor again.
- R8: A disable write (run_val_i=0) during a transfer keeps run_state_o at 1 until xfer_done_i. The block then stops with the address already advanced and raises no further fetch.
- R9: A disable write in suspend stops at once. A disable write during a fetch takes effect on the fetch response, with no transfer, no suspend and the address unchanged.
- R10: An enable write while running and a disable write while stopped change neither the state nor the address.
- R11: nobuf_o stays set until a nobuf_clr_i pulse clears it; a new set in the same cycle wins over the clear.
- R12: fetch_req_o stays high with a stable fetch_addr_o until fetch_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_wr_i | input | 1 | Run bit write strobe |
| run_val_i | input | 1 | Run bit value written |
| base_wr_i | input | 1 | Table base write strobe |
| base_val_i | input | AW | Table base value |
| nobuf_clr_i | input | 1 | Write-one-to-clear for nobuf_o |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_addr_o | output | AW | Descriptor fetch address |
| fetch_ack_i | input | 1 | Fetch response valid |
| fetch_avail_i | input | 1 | Fetched descriptor is available |
| fetch_eor_i | input | 1 | Fetched descriptor ends the ring |
| xfer_start_o | output | 1 | One-cycle frame transfer start |
| xfer_done_i | input | 1 | Frame transfer finished |
| nobuf_o | output | 1 | Sticky no-buffer flag |
| run_state_o | output | 2 | 0 stop, 1 running, 2 suspend |
| cur_addr_o | output | AW | Current descriptor address |

## Verification
The ring walk is first driven with hand-picked sequences: plain advance, wrap at the end-of-ring descriptor, an empty descriptor, and disable or enable writes placed during a fetch, during a transfer, in suspend and in stop. These sequences separate deferred stops from immediate ones and resumed addresses from reloaded ones. A random phase then uses a five-entry ring with random fetch latency, transfer length, empty descriptors, flag clears and stops in the middle of a transfer. It tracks the expected address through wraps and restarts, which exposes any off-by-one descriptor after a stop or a suspend.

// File: rtl/rxdma_run_pkg.sv
package rxdma_run_pkg;
  typedef enum logic [1:0] {
    RS_STOP = 2'd0,
    RS_RUN  = 2'd1,
    RS_SUSP = 2'd2
  } run_state_e;

  typedef enum logic [1:0] {
    FS_STOP,
    FS_FETCH,
    FS_XFER,
    FS_SUSP
  } fsm_state_e;
endpackage

// File: rtl/rxdma_cmd_filter.sv
module rxdma_cmd_filter
  import rxdma_run_pkg::*;
(
  input  logic       run_wr_i,
  input  logic       run_val_i,
  input  fsm_state_e st_i,
  output logic       go_o,
  output logic       halt_o
);
  // enable honoured from stop/suspend, disable from anything but stop
  assign go_o   = run_wr_i & run_val_i & ((st_i == FS_STOP) | (st_i == FS_SUSP));
  assign halt_o = run_wr_i & ~run_val_i & (st_i != FS_STOP);
endmodule

// File: rtl/rxdma_addr_trk.sv
module rxdma_addr_trk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_val_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] base_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] cur_q, base_q;
  logic          fresh_q;  // base written since last start

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      base_q  <= '0;
      fresh_q <= 1'b1;
    end else begin
      if (load_i) begin
        if (fresh_q) cur_q <= base_q;
        fresh_q <= 1'b0;
      end else if (adv_i) begin
        cur_q <= wrap_i ? base_q : cur_q + STEP;
      end
      if (base_wr_i) begin
        base_q  <= base_val_i;
        fresh_q <= 1'b1;
      end
    end
  end

  assign cur_o  = cur_q;
  assign base_o = base_q;
endmodule

// File: rtl/rxdma_run_fsm.sv
module rxdma_run_fsm
  import rxdma_run_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       halt_i,
  input  logic       fetch_ack_i,
  input  logic       fetch_avail_i,
  input  logic       fetch_eor_i,
  input  logic       xfer_done_i,
  input  logic       nobuf_clr_i,
  output fsm_state_e st_o,
  output logic       load_o,
  output logic       adv_o,
  output logic       wrap_o,
  output logic       xfer_start_o,
  output logic       nobuf_o
);
  fsm_state_e st_q;
  logic pend_q, eor_q, start_q, nobuf_q;
  logic stop_now, nobuf_set;

  assign stop_now  = pend_q | halt_i;
  assign nobuf_set = (st_q == FS_FETCH) & fetch_ack_i & ~stop_now & ~fetch_avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FS_STOP;
      pend_q  <= 1'b0;
      eor_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        FS_STOP: if (go_i) st_q <= FS_FETCH;
        FS_FETCH: begin
          if (halt_i) pend_q <= 1'b1;
          if (fetch_ack_i) begin
            if (stop_now) begin
              st_q   <= FS_STOP;
              pend_q <= 1'b0;
            end else if (fetch_avail_i) begin
              st_q    <= FS_XFER;
              eor_q   <= fetch_eor_i;
              start_q <= 1'b1;
            end else begin
              st_q <= FS_SUSP;
            end
          end
        end
        FS_XFER: begin
          if (halt_i) pend_q <= 1'b1;
          if (xfer_done_i) begin
            if (stop_now) begin
              st_q   <= FS_STOP;
              pend_q <= 1'b0;
            end else begin
              st_q <= FS_FETCH;
            end
          end
        end
        FS_SUSP: begin
          if (go_i)        st_q <= FS_FETCH;
          else if (halt_i) st_q <= FS_STOP;
        end
        default: st_q <= FS_STOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          nobuf_q <= 1'b0;
    else if (nobuf_set)   nobuf_q <= 1'b1;
    else if (nobuf_clr_i) nobuf_q <= 1'b0;
  end

  assign st_o         = st_q;
  assign load_o       = (st_q == FS_STOP) & go_i;
  assign adv_o        = (st_q == FS_XFER) & xfer_done_i;
  assign wrap_o       = eor_q;
  assign xfer_start_o = start_q;
  assign nobuf_o      = nobuf_q;
endmodule

// File: rtl/rxdma_run_ctl.sv
module rxdma_run_ctl
  import rxdma_run_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_wr_i,
  input  logic          run_val_i,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_val_i,
  input  logic          nobuf_clr_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_ack_i,
  input  logic          fetch_avail_i,
  input  logic          fetch_eor_i,
  output logic          xfer_start_o,
  input  logic          xfer_done_i,
  output logic          nobuf_o,
  output logic [1:0]    run_state_o,
  output logic [AW-1:0] cur_addr_o
);
  fsm_state_e    st;
  logic          go, halt, load, adv, wrap;
  logic [AW-1:0] cur_addr, tbl_base;

  rxdma_cmd_filter u_filt (
    .run_wr_i (run_wr_i),
    .run_val_i(run_val_i),
    .st_i     (st),
    .go_o     (go),
    .halt_o   (halt)
  );

  rxdma_run_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go),
    .halt_i       (halt),
    .fetch_ack_i  (fetch_ack_i),
    .fetch_avail_i(fetch_avail_i),
    .fetch_eor_i  (fetch_eor_i),
    .xfer_done_i  (xfer_done_i),
    .nobuf_clr_i  (nobuf_clr_i),
    .st_o         (st),
    .load_o       (load),
    .adv_o        (adv),
    .wrap_o       (wrap),
    .xfer_start_o (xfer_start_o),
    .nobuf_o      (nobuf_o)
  );

  rxdma_addr_trk #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_wr_i (base_wr_i),
    .base_val_i(base_val_i),
    .load_i    (load),
    .adv_i     (adv),
    .wrap_i    (wrap),
    .cur_o     (cur_addr),
    .base_o    (tbl_base)
  );

  always_comb begin
    case (st)
      FS_FETCH, FS_XFER: run_state_o = RS_RUN;
      FS_SUSP:           run_state_o = RS_SUSP;
      default:           run_state_o = RS_STOP;
    endcase
  end

  assign fetch_req_o  = (st == FS_FETCH);
  assign fetch_addr_o = cur_addr;
  assign cur_addr_o   = cur_addr;
endmodule

// File: rtl/rxdma_run_chk.sv
module rxdma_run_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_wr_i,
  input logic          run_val_i,
  input logic          nobuf_clr_i,
  input logic          fetch_req_o,
  input logic [AW-1:0] fetch_addr_o,
  input logic          fetch_ack_i,
  input logic          fetch_avail_i,
  input logic          xfer_start_o,
  input logic          xfer_done_i,
  input logic          nobuf_o,
  input logic [1:0]    run_state_o,
  input logic [AW-1:0] cur_addr_o,
  input logic [AW-1:0] tbl_base
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);
  localparam logic [1:0] S_STOP = 2'd0, S_RUN = 2'd1, S_SUSP = 2'd2;

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_addr_o));

  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  assert_start_in_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> run_state_o == S_RUN && !fetch_req_o);

  assert_empty_no_xfer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_ack_i && !fetch_avail_i |=> !xfer_start_o && run_state_o != S_RUN);

  assert_flag_in_susp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nobuf_o) |-> run_state_o == S_SUSP);

  assert_xfer_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_state_o == S_RUN && !fetch_req_o && !xfer_done_i |=> run_state_o == S_RUN);

  assert_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_state_o == S_RUN && !fetch_req_o && xfer_done_i
    |=> cur_addr_o == $past(cur_addr_o) + STEP || cur_addr_o == tbl_base);

  assert_stop_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_state_o == S_STOP && !(run_wr_i && run_val_i) |=> run_state_o == S_STOP);

  assert_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nobuf_o && !nobuf_clr_i |=> nobuf_o);
endmodule

bind rxdma_run_ctl rxdma_run_chk #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_wr_i     (run_wr_i),
  .run_val_i    (run_val_i),
  .nobuf_clr_i  (nobuf_clr_i),
  .fetch_req_o  (fetch_req_o),
  .fetch_addr_o (fetch_addr_o),
  .fetch_ack_i  (fetch_ack_i),
  .fetch_avail_i(fetch_avail_i),
  .xfer_start_o (xfer_start_o),
  .xfer_done_i  (xfer_done_i),
  .nobuf_o      (nobuf_o),
  .run_state_o  (run_state_o),
  .cur_addr_o   (cur_addr_o),
  .tbl_base     (tbl_base)
);

// File: tb/tb_rxdma_run_ctl.sv
module tb_rxdma_run_ctl;
  localparam logic [1:0] S_STOP = 2'd0, S_RUN = 2'd1, S_SUSP = 2'd2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        run_wr_i = 0, run_val_i = 0, base_wr_i = 0, nobuf_clr_i = 0;
  logic [31:0] base_val_i = '0;
  logic        fetch_ack_i = 0, fetch_avail_i = 0, fetch_eor_i = 0, xfer_done_i = 0;
  logic        fetch_req_o, xfer_start_o, nobuf_o;
  logic [31:0] fetch_addr_o, cur_addr_o;
  logic [1:0]  run_state_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] m_base = '0, m_addr = '0;
  bit m_fresh = 1;

  always #4 clk_i = ~clk_i;

  rxdma_run_ctl #(.AW(32), .DESC_BYTES(16)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_wr_i(run_wr_i), .run_val_i(run_val_i),
    .base_wr_i(base_wr_i), .base_val_i(base_val_i), .nobuf_clr_i(nobuf_clr_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i),
    .fetch_avail_i(fetch_avail_i), .fetch_eor_i(fetch_eor_i), .xfer_start_o(xfer_start_o),
    .xfer_done_i(xfer_done_i), .nobuf_o(nobuf_o), .run_state_o(run_state_o),
    .cur_addr_o(cur_addr_o)
  );

  function automatic logic [31:0] next_desc(input logic [31:0] a, input logic [31:0] b,
                                            input bit eor);
    return eor ? b : a + 32'd16;
  endfunction

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    base_wr_i = 1; base_val_i = b; step(); base_wr_i = 0;
    m_base = b; m_fresh = 1;
  endtask

  task automatic wr_run(input bit v);
    if (v && run_state_o == S_STOP) begin
      if (m_fresh) m_addr = m_base;
      m_fresh = 0;
    end
    run_wr_i = 1; run_val_i = v; step(); run_wr_i = 0; run_val_i = 0;
  endtask

  task automatic do_fetch(input bit avail, input bit eor, input int lat, input string tag);
    chk(fetch_req_o == 1'b1, tag, {31'd0, fetch_req_o}, 32'd1);
    chk(fetch_addr_o == m_addr, tag, fetch_addr_o, m_addr);
    for (int i = 0; i < lat; i++) begin
      step();
      chk(fetch_req_o && fetch_addr_o == m_addr, "R12", fetch_addr_o, m_addr);
    end
    fetch_ack_i = 1; fetch_avail_i = avail; fetch_eor_i = eor;
    step();
    fetch_ack_i = 0; fetch_avail_i = 0; fetch_eor_i = 0;
  endtask

  task automatic do_xfer(input bit eor, input int dly, input bit stop_mid);
    chk(xfer_start_o == 1'b1, "R4", {31'd0, xfer_start_o}, 32'd1);
    chk(run_state_o == S_RUN, "R4", {30'd0, run_state_o}, {30'd0, S_RUN});
    step();
    chk(xfer_start_o == 1'b0, "R4", {31'd0, xfer_start_o}, 32'd0);
    if (stop_mid) begin
      wr_run(0);
      chk(run_state_o == S_RUN, "R8", {30'd0, run_state_o}, {30'd0, S_RUN});
    end
    for (int i = 0; i < dly; i++) begin
      step();
      chk(run_state_o == S_RUN && !fetch_req_o, "R8", {30'd0, run_state_o}, {30'd0, S_RUN});
    end
    xfer_done_i = 1; step(); xfer_done_i = 0;
    m_addr = next_desc(m_addr, m_base, eor);
    chk(cur_addr_o == m_addr, "R5", cur_addr_o, m_addr);
    if (stop_mid) begin
      chk(run_state_o == S_STOP, "R8", {30'd0, run_state_o}, {30'd0, S_STOP});
      chk(fetch_req_o == 1'b0, "R8", {31'd0, fetch_req_o}, 32'd0);
    end else begin
      chk(fetch_req_o && fetch_addr_o == m_addr, "R5", fetch_addr_o, m_addr);
    end
  endtask

  task automatic chk_susp();
    chk(run_state_o == S_SUSP, "R6", {30'd0, run_state_o}, {30'd0, S_SUSP});
    chk(nobuf_o == 1'b1, "R6", {31'd0, nobuf_o}, 32'd1);
    chk(xfer_start_o == 1'b0, "R6", {31'd0, xfer_start_o}, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2917));
    repeat (3) step();
    rst_ni = 1;
    step();
    // R1 reset state
    chk(run_state_o == S_STOP, "R1", {30'd0, run_state_o}, 32'd0);
    chk(cur_addr_o == 32'd0, "R1", cur_addr_o, 32'd0);
    chk(!nobuf_o && !fetch_req_o && !xfer_start_o, "R1",
        {29'd0, nobuf_o, fetch_req_o, xfer_start_o}, 32'd0);

    // R2 start at new base
    set_base(32'h1000);
    wr_run(1);
    chk(run_state_o == S_RUN, "R2", {30'd0, run_state_o}, {30'd0, S_RUN});
    do_fetch(1, 0, 1, "R2");
    do_xfer(0, 2, 0);
    // R10 enable while running ignored
    wr_run(1);
    chk(run_state_o == S_RUN && cur_addr_o == m_addr, "R10", cur_addr_o, m_addr);
    do_fetch(1, 1, 0, "R5");
    do_xfer(1, 1, 0);  // wraps to base
    // R6 empty descriptor
    do_fetch(0, 0, 2, "R5");
    chk_susp();
    repeat (3) step();
    chk(nobuf_o == 1'b1, "R11", {31'd0, nobuf_o}, 32'd1);
    // R7 re-fetch same descriptor
    wr_run(1);
    do_fetch(1, 0, 0, "R7");
    // R11 clear via write-one-to-clear while running
    nobuf_clr_i = 1; step(); nobuf_clr_i = 0;
    chk(nobuf_o == 1'b0, "R11", {31'd0, nobuf_o}, 32'd0);
    // previous ack already consumed one cycle; start pulse gone, finish transfer manually
    xfer_done_i = 1; step(); xfer_done_i = 0;
    m_addr = next_desc(m_addr, m_base, 0);
    chk(fetch_req_o && fetch_addr_o == m_addr, "R5", fetch_addr_o, m_addr);
    // R8 deferred stop
    do_fetch(1, 0, 0, "R5");
    do_xfer(0, 3, 1);
    // R10 disable in stop ignored
    wr_run(0);
    chk(run_state_o == S_STOP && cur_addr_o == m_addr, "R10", cur_addr_o, m_addr);
    // R3 resume after stop
    wr_run(1);
    chk(fetch_addr_o == 32'h1020, "R3", fetch_addr_o, 32'h1020);
    // R9 stop during fetch
    wr_run(0);
    chk(run_state_o == S_RUN && fetch_req_o, "R9", {30'd0, run_state_o}, {30'd0, S_RUN});
    do_fetch(0, 0, 1, "R9");
    chk(run_state_o == S_STOP, "R9", {30'd0, run_state_o}, {30'd0, S_STOP});
    chk(nobuf_o == 1'b0 && cur_addr_o == m_addr, "R9", cur_addr_o, m_addr);
    // R9 stop from suspend
    wr_run(1);
    do_fetch(0, 0, 0, "R3");
    chk_susp();
    wr_run(0);
    chk(run_state_o == S_STOP, "R9", {30'd0, run_state_o}, {30'd0, S_STOP});
    // R11 set wins over clear: suspend entry with clear asserted
    nobuf_clr_i = 1; step(); nobuf_clr_i = 0;
    wr_run(1);
    fetch_ack_i = 1; nobuf_clr_i = 1; step();
    fetch_ack_i = 0; nobuf_clr_i = 0;
    chk(nobuf_o == 1'b1, "R11", {31'd0, nobuf_o}, 32'd1);
    wr_run(0);
    // R2 new base after stop
    set_base(32'h2000);
    wr_run(1);
    do_fetch(0, 0, 0, "R2");
    chk_susp();
    wr_run(0);
    nobuf_clr_i = 1; step(); nobuf_clr_i = 0;

    // random ring walk, five descriptors
    set_base(32'h4000);
    wr_run(1);
    for (int n = 0; n < 300; n++) begin
      bit av, eor, stp;
      int idx;
      idx = int'((m_addr - m_base) >> 4);
      av  = ($urandom_range(0, 9) != 0);
      eor = (idx == 4);
      do_fetch(av, eor, $urandom_range(0, 3), "R5");
      if (av) begin
        stp = ($urandom_range(0, 7) == 0);
        do_xfer(eor, $urandom_range(0, 4), stp);
        if (stp) wr_run(1);
      end else begin
        chk_susp();
        if ($urandom_range(0, 1) == 1) begin
          nobuf_clr_i = 1; step(); nobuf_clr_i = 0;
          chk(nobuf_o == 1'b0, "R11", {31'd0, nobuf_o}, 32'd0);
        end
        wr_run(1);  // R7 same descriptor checked by next fetch
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule